// File: doc/BRIEF.md
# Augmented Serial CRC Encoder and Checker

This block computes a cyclic redundancy checksum one bit per clock, with a degree-3 generator polynomial, x^3 + x^2 + 1, set by parameter. The remainder register has one stage per degree of the generator. Each incoming bit is shifted into the bottom stage. When the bit leaving the top stage is one, the generator's low coefficients are XORed into the register. That is polynomial division with modulo-two arithmetic, where subtraction is an exclusive OR.

In encode mode the caller streams a message, most significant bit first. After the bit marked last, the block feeds three zero bits of its own, which extends the message on the right by the polynomial degree. The remainder left over is the checksum. Appending it to the message gives a word that divides evenly by the generator, and the message bits in that word are unchanged.

In check mode the caller streams a message with its checksum attached. The block flags success when the final remainder is zero. It also replays the stream with the last three bits held back, which returns the original message.

Top module: `crc_aug_serial`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, done_o, ok_o, out_valid_o and crc_o are all zero.
- R2: A cycle with start_i high clears the remainder and the strip delay line, and latches mode_i (0 = encode, 1 = check). A valid_i bit presented in that same cycle is not taken.
- R3: Every bit that is taken shifts the remainder by one step, most significant bit first, using the default generator 1101. crc_o shows the updated remainder from the cycle after the shift.
- R4: In encode mode, the block makes three internal zero shifts in the three cycles after the last bit is taken. valid_i is ignored during those cycles. done_o rises in the cycle after the final zero shift, and crc_o then holds the checksum. For the message 0xD6B5 the checksum is 0b101, and the transmitted word is 0x6B5AD.
- R5: In check mode, done_o rises in the cycle after the last bit is taken. With done_o high, ok_o is 1 exactly when crc_o is zero. Checking 0x6B5AD (19 bits) gives ok_o = 1.
- R6: Flipping any single bit of a valid codeword makes ok_o 0 at done_o.
- R7: ok_o is never high unless done_o is high, and it is never high in encode mode.
- R8: In encode mode, out_valid_o is high in the cycle after each bit is taken, and out_bit_o carries that bit.
- R9: In check mode, the first three bits taken produce no output. Each later bit that is taken produces one output bit in the next cycle: the bit taken three bits earlier. The checksum is therefore never replayed.
- R10: Before any start_i, and after done_o, valid_i is ignored: crc_o holds its value and out_valid_o stays low.
- R11: done_o is high for exactly one cycle per frame. crc_o keeps the final remainder until the next start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new frame |
| mode_i | input | 1 | Mode latched at start: 0 encode, 1 check |
| valid_i | input | 1 | bit_i is presented this cycle |
| bit_i | input | 1 | Serial data bit, most significant first |
| last_i | input | 1 | Marks the final bit of the frame |
| out_valid_o | output | 1 | out_bit_o is valid |
| out_bit_o | output | 1 | Message bit replayed (checksum stripped in check mode) |
| done_o | output | 1 | One-cycle frame-complete pulse |
| ok_o | output | 1 | Zero remainder in check mode, qualified by done_o |
| crc_o | output | 3 | Current remainder |

## Verification
The known 16-bit message and its 19-bit codeword pin the checksum value and the zero remainder against one fixed answer. Every single-bit corruption of that codeword shows whether a lone flipped bit anywhere, including inside the checksum, is detected. Random frames of mixed lengths and modes are sent with idle gaps between bits and with valid_i left high during the zero-padding cycles. These show whether only taken bits shift, and whether the strip delay drops exactly the last three bits. A restart in the middle of a frame, with start_i and valid_i high together, shows whether start takes priority and clears the state.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_PAD  = 2'd2
  } phase_e;

  // One division step: shift in a bit, subtract the generator when the top stage overflows
  function automatic logic [31:0] crc_step(logic [31:0] st, logic b,
                                           logic [31:0] taps, int deg);
    logic [31:0] mask;
    logic [31:0] nxt;
    logic        fb;
    mask = (32'h1 << deg) - 32'h1;
    fb   = st[deg-1];
    nxt  = ((st << 1) | {31'h0, b}) & mask;
    if (fb) nxt = nxt ^ (taps & mask);
    return nxt;
  endfunction

endpackage

// File: rtl/crc_shift_reg.sv
module crc_shift_reg #(
  parameter int             DEG  = 3,
  parameter logic [DEG-1:0] TAPS = 3'b101
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           shift_i,
  input  logic           din_i,
  output logic [DEG-1:0] rem_o
);
  import crc_pkg::*;

  logic [DEG-1:0] rem_q;
  logic [31:0]    step_w;

  assign step_w = crc_step(32'(rem_q), din_i, 32'(TAPS), DEG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (clr_i)   rem_q <= '0;
    else if (shift_i) rem_q <= step_w[DEG-1:0];
  end

  assign rem_o = rem_q;

  // R2: a start leaves an empty remainder
  p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> rem_q == '0);
  // R10: without a shift the remainder holds
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !shift_i) |=> rem_q == $past(rem_q));

endmodule

// File: rtl/crc_strip_delay.sv
module crc_strip_delay #(
  parameter int DEG = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic push_i,
  input  logic din_i,
  input  logic strip_i,
  output logic ov_o,
  output logic ob_o
);
  localparam int CW = $clog2(DEG + 1);

  logic [DEG-1:0] hold_q;
  logic [CW-1:0]  fill_q;
  logic           full_w;
  logic           ov_q, ob_q;

  assign full_w = (fill_q == CW'(DEG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      fill_q <= '0;
      ov_q   <= 1'b0;
      ob_q   <= 1'b0;
    end else if (clr_i) begin
      hold_q <= '0;
      fill_q <= '0;
      ov_q   <= 1'b0;
      ob_q   <= 1'b0;
    end else if (push_i) begin
      hold_q <= {hold_q[DEG-2:0], din_i};
      if (!full_w) fill_q <= fill_q + CW'(1);
      ov_q   <= strip_i ? full_w : 1'b1;
      ob_q   <= strip_i ? hold_q[DEG-1] : din_i;
    end else begin
      ov_q   <= 1'b0;
    end
  end

  assign ov_o = ov_q;
  assign ob_o = ob_q;

  // R8: an output bit only ever follows an accepted input bit
  p_out_follows_push_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_q |-> $past(push_i));
  // R9: in strip mode nothing leaves before the line has filled
  p_strip_waits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && strip_i && !clr_i && fill_q == '0) |=> !ov_q);

endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl #(
  parameter int DEG = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  input  logic valid_i,
  input  logic last_i,
  output logic clr_o,
  output logic shift_o,
  output logic push_o,
  output logic zero_o,
  output logic check_o,
  output logic done_o
);
  import crc_pkg::*;
  localparam int CW = $clog2(DEG + 1);

  phase_e        ph_q;
  logic [CW-1:0] pad_q;
  logic          check_q, done_q;
  logic          take_w, pad_w;

  assign take_w  = !start_i && ph_q == PH_RUN && valid_i;
  assign pad_w   = !start_i && ph_q == PH_PAD;
  assign clr_o   = start_i;
  assign push_o  = take_w;
  assign shift_o = take_w || pad_w;
  assign zero_o  = pad_w;
  assign check_o = check_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      pad_q   <= '0;
      check_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        ph_q    <= PH_RUN;
        pad_q   <= '0;
        check_q <= mode_i;
      end else begin
        case (ph_q)
          PH_RUN: if (valid_i && last_i) begin
            if (check_q) begin
              ph_q   <= PH_IDLE;
              done_q <= 1'b1;
            end else begin
              ph_q  <= PH_PAD;
              pad_q <= CW'(DEG);
            end
          end
          PH_PAD: begin
            pad_q <= pad_q - CW'(1);
            if (pad_q == CW'(1)) begin
              ph_q   <= PH_IDLE;
              done_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: completion is a single-cycle pulse
  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R4: the final zero shift is followed by done
  p_pad_ends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_w && pad_q == CW'(1)) |=> done_q);
  // R2: start has priority over a presented bit
  p_start_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !shift_o);

endmodule

// File: rtl/crc_aug_serial.sv
module crc_aug_serial #(
  parameter int             DEG  = 3,
  parameter logic [DEG-1:0] TAPS = 3'b101
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           mode_i,
  input  logic           valid_i,
  input  logic           bit_i,
  input  logic           last_i,
  output logic           out_valid_o,
  output logic           out_bit_o,
  output logic           done_o,
  output logic           ok_o,
  output logic [DEG-1:0] crc_o
);
  logic clr_w, shift_w, push_w, zero_w, check_w, done_w;
  logic [DEG-1:0] rem_w;

  crc_seq_ctrl #(.DEG(DEG)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .valid_i(valid_i), .last_i(last_i), .clr_o(clr_w), .shift_o(shift_w),
    .push_o(push_w), .zero_o(zero_w), .check_o(check_w), .done_o(done_w)
  );

  crc_shift_reg #(.DEG(DEG), .TAPS(TAPS)) u_rem (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_w), .shift_i(shift_w),
    .din_i(zero_w ? 1'b0 : bit_i), .rem_o(rem_w)
  );

  crc_strip_delay #(.DEG(DEG)) u_strip (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_w), .push_i(push_w),
    .din_i(bit_i), .strip_i(check_w), .ov_o(out_valid_o), .ob_o(out_bit_o)
  );

  assign crc_o  = rem_w;
  assign done_o = done_w;
  assign ok_o   = done_w && check_w && (rem_w == '0);

  // R7: ok is qualified by done
  p_ok_in_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> done_o);
  // R11: remainder is frozen the cycle after done unless restarted
  p_hold_after_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> crc_o == $past(crc_o));

endmodule

// File: tb/test_crc_aug_serial.sv
module test_crc_aug_serial;
  localparam int DEG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, valid = 1'b0, din = 1'b0, last = 1'b0;
  logic ov, ob, done, ok;
  logic [DEG-1:0] crc;

  int nchk = 0, nfail = 0, cyc = 0;

  always #2 clk = ~clk;

  crc_aug_serial i_crc_aug_serial (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .valid_i(valid), .bit_i(din), .last_i(last), .out_valid_o(ov),
    .out_bit_o(ob), .done_o(done), .ok_o(ok), .crc_o(crc)
  );

  task automatic chk(bit cond, string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Reference remainder by long division over an integer word
  function automatic int ref_rem(logic [63:0] w, int n);
    int r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      r = (r << 1) | int'(w[i]);
      if (r & 8) r = r ^ 'hD;
    end
    return r;
  endfunction

  // Behavioural cycle model
  int  m_phase = 0, m_pad = 0, m_rem = 0;
  bit  m_check = 0;
  bit  m_q[$];
  bit  e_done = 0, e_ok = 0, e_ov = 0, e_ob = 0;
  int  e_crc = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_pad = 0; m_rem = 0; m_check = 0; m_q.delete();
      e_done = 0; e_ok = 0; e_ov = 0; e_ob = 0; e_crc = 0;
    end else begin
      e_done = 0; e_ok = 0; e_ov = 0;
      if (start) begin
        m_phase = 1; m_check = mode; m_rem = 0; m_q.delete(); e_ob = 0;
      end else if (m_phase == 1 && valid) begin
        m_rem = (m_rem << 1) | int'(din);
        if (m_rem & 8) m_rem = m_rem ^ 'hD;
        if (!m_check) begin
          e_ov = 1; e_ob = din;
        end else begin
          m_q.push_back(din);
          if (m_q.size() > DEG) begin e_ov = 1; e_ob = m_q.pop_front(); end
        end
        if (last) begin
          if (m_check) begin m_phase = 0; e_done = 1; e_ok = (m_rem == 0); end
          else begin m_phase = 2; m_pad = DEG; end
        end
      end else if (m_phase == 2) begin
        m_rem = m_rem << 1;
        if (m_rem & 8) m_rem = m_rem ^ 'hD;
        m_pad--;
        if (m_pad == 0) begin m_phase = 0; e_done = 1; end
      end
      e_crc = m_rem;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(crc == DEG'(e_crc), "R3 crc", 64'(crc), 64'(e_crc));
      chk(done == e_done, "R11 done", 64'(done), 64'(e_done));
      chk(ok == e_ok, "R5 ok", 64'(ok), 64'(e_ok));
      chk(ov == e_ov, "R8 out_valid", 64'(ov), 64'(e_ov));
      if (e_ov) chk(ob == e_ob, "R9 out_bit", 64'(ob), 64'(e_ob));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic send_frame(bit md, logic [63:0] w, int n, bit gaps,
                            output int rcrc, output bit rok);
    @(negedge clk);
    start = 1; mode = md; valid = 0; last = 0;
    @(negedge clk);
    start = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (gaps && ($urandom % 3 == 0)) begin
        valid = 0; din = 1'($urandom); @(negedge clk);
      end
      valid = 1; din = w[i]; last = (i == 0);
      @(negedge clk);
    end
    last = 0;
    valid = gaps;          // R4: noise on valid during the padding cycles
    din = 1;
    rcrc = -1; rok = 0;
    for (int k = 0; k < 10; k++) begin
      if (done) begin rcrc = int'(crc); rok = ok; break; end
      @(negedge clk);
    end
    valid = 0;
    chk(rcrc >= 0, "R11 done seen", 64'(rcrc), 64'(0));
  endtask

  initial begin
    int  c;
    bit  o;
    logic [63:0] cw;
    repeat (3) @(negedge clk);
    chk(!done && !ok && !ov && crc == 0, "R1 reset", {ov, done, ok, crc}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !ok && !ov && crc == 0, "R1 after release", {ov, done, ok, crc}, 0);

    // R10: bits offered with no frame open
    valid = 1; din = 1;
    repeat (4) @(negedge clk);
    chk(crc == 0 && !ov, "R10 idle valid ignored", {ov, crc}, 0);
    valid = 0;

    // R4: known message
    send_frame(0, 64'hD6B5, 16, 0, c, o);
    chk(c == 5, "R4 checksum of 0xD6B5", 64'(c), 64'd5);
    chk(({48'h0, 16'hD6B5} << 3 | 64'(c)) == 64'h6B5AD, "R4 transmitted word",
        ({48'h0, 16'hD6B5} << 3 | 64'(c)), 64'h6B5AD);
    chk(!o, "R7 no ok in encode", 64'(o), 0);

    // R11: remainder held after done; R10 ignored after done
    valid = 1; din = 1;
    repeat (3) @(negedge clk);
    valid = 0;
    chk(crc == 3'd5, "R11 hold after done", 64'(crc), 64'd5);

    // R5: known codeword
    send_frame(1, 64'h6B5AD, 19, 0, c, o);
    chk(o && c == 0, "R5 codeword ok", {o, 3'(c)}, 4'h8);

    // R6: every single-bit error
    for (int p = 0; p < 19; p++) begin
      send_frame(1, 64'h6B5AD ^ (64'h1 << p), 19, p[0], c, o);
      chk(!o && c != 0, "R6 single-bit error", {o, 3'(c)}, 0);
    end

    // R2: restart mid-frame with valid high in the start cycle
    @(negedge clk);
    start = 1; mode = 1; @(negedge clk); start = 0;
    valid = 1; din = 1; repeat (5) @(negedge clk);
    start = 1; mode = 0; @(negedge clk);
    start = 0; valid = 0;
    chk(crc == 0 && !ov, "R2 start clears, bit not taken", {ov, crc}, 0);
    send_frame(0, 64'h2D, 6, 0, c, o);
    chk(c == ref_rem(64'h2D << 3, 9), "R4 short frame", 64'(c), 64'(ref_rem(64'h2D << 3, 9)));

    // Random frames of both modes, some with gaps
    for (int f = 0; f < 40; f++) begin
      int  n   = 4 + int'($urandom % 37);
      bit  md  = 1'($urandom);
      logic [63:0] msg = {$urandom, $urandom} & ((64'h1 << n) - 1);
      int  ck  = ref_rem(msg << 3, n + 3);
      if (md) begin
        cw = (msg << 3) | 64'(ck);
        send_frame(1, cw, n + 3, 1'($urandom), c, o);
        chk(o == 1, "R5 random codeword", 64'(o), 64'd1);
      end else begin
        send_frame(0, msg, n, 1'($urandom), c, o);
        chk(c == ck, "R4 random checksum", 64'(c), 64'(ck));
      end
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule